// File: doc/BRIEF.md
# Three-Stage Queue-Coupled Elastic Pipeline

This block moves a stream of words through three transform stages, with a small queue on each side of every stage instead of a plain pipeline register. Every stage decides for itself, every cycle, whether to advance one word. It advances when the queue in front of it holds something and the queue behind it can take a word. Because of this local rule, the pipeline carries no per-word valid tags. Which words are live is known only from how full each queue is.

Words enter through a ready/valid input port into an entry queue. They pass through stage one, a first inner queue, stage two, a second inner queue and stage three, and land in an exit queue that drives a ready/valid output port. Every queue can be written and read in the same cycle, even when it is full. A read by the downstream stage frees the slot in time for the upstream write. With this, all three stages can move at once, and the block sustains one word per clock with no gaps.

The transforms are simple stand-ins for a real datapath:
- stage one adds a constant;
- stage two XORs with a mask;
- stage three rotates left by one bit.

Top module: `elastic_pipe`

## Requirements
- R1: While reset is high and after any clock edge at which reset was high, every queue is empty, `outValid` is 0 and `inReady` is 1. This holds equally for a reset applied mid-stream.
- R2: Each delivered word equals rotl1((x + STAGE1_ADD) ^ STAGE2_MASK) for input word x, where rotl1 moves bit DATA_W-1 to bit 0. Words leave in the order they were accepted.
- R3: In an empty pipeline with `outReady` high, a word accepted at clock edge t shows `outValid` high with its result after edge t+3, and not before.
- R4: With `outReady` held high and a word offered every cycle, `inReady` never drops. After the three-edge fill, one word is delivered on every cycle with no gap.
- R5: A stage advances only when its source queue is non-empty and its destination queue has room. With `outReady` low, the block therefore accepts exactly 4*DEPTH words and then drops `inReady`. No queue ever holds more than DEPTH words.
- R6: A full queue that is read in a cycle accepts a write in that same cycle. When the whole pipeline is full, raising `outReady` raises `inReady` in the same cycle.
- R7: While `outValid` is high and `outReady` is low, `outValid` stays high and `outData` stays unchanged on the next cycle.
- R8: Under any pattern of input and output stalls, no word is lost or duplicated. The number of words held changes each cycle by exactly the input handshakes minus the output handshakes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, empties all queues |
| inValid | input | 1 | Input word offered |
| inReady | output | 1 | Entry queue can take a word this cycle |
| inData | input | DATA_W | Input word |
| outValid | output | 1 | Exit queue holds a result |
| outReady | input | 1 | Consumer takes the result this cycle |
| outData | output | DATA_W | Oldest result in the exit queue |

## Verification
An accepted word crosses three stage edges before it becomes visible. Its result is therefore due on the output in the sample after the fourth edge, counting the accepting edge, and the latency test checks `outValid` low in the three samples before that and high exactly there.

`inReady` is combinational from the queue states and `outReady`. The bench therefore drives inputs on the falling edge and samples one nanosecond later, before the next rising edge. In that same sample it sees the same-cycle release of a full pipeline.

Throughput is checked by recording, sample by sample, the window in which results are valid and requiring twenty consecutive valid samples starting at the fourth sample. A scoreboard built from R2 compares every delivered word in order, including during random stalls.

// File: rtl/elastic_pkg.sv
package elastic_pkg;

  // three transform stages, each sitting between two queues
  localparam int NUM_STAGES = 3;
  localparam int NUM_QUEUES = NUM_STAGES + 1;

  // strobes from control to datapath: per-queue write and read
  typedef struct packed {
    logic [NUM_QUEUES-1:0] push;
    logic [NUM_QUEUES-1:0] pop;
  } strobe_t;

  // queue state from datapath to control
  typedef struct packed {
    logic [NUM_QUEUES-1:0] notEmpty;
    logic [NUM_QUEUES-1:0] full;
  } status_t;

endpackage

// File: rtl/elastic_fifo.sv
module elastic_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 2,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] headData,
  output logic              notEmpty,
  output logic              full,
  output logic [CW-1:0]     count
);

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wrPtr;
  logic [PW-1:0]     rdPtr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // storage carries no reset: occupancy alone says what is live
  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  assign headData = mem[rdPtr];
  assign notEmpty = (count != '0);
  assign full     = (count == CAP);

endmodule

// File: rtl/elastic_ctrl.sv
module elastic_ctrl
  import elastic_pkg::*;
(
  input  status_t status,
  input  logic    inValid,
  input  logic    outReady,
  output logic    inReady,
  output logic    outValid,
  output strobe_t strobe
);

  localparam int LASTQ = NUM_QUEUES - 1;

  logic [NUM_QUEUES-1:0] popV;

  // resolve firing from the output back to the input, so a same-cycle
  // read of a full queue frees room for the stage in front of it
  always_comb begin
    popV        = '0;
    popV[LASTQ] = status.notEmpty[LASTQ] & outReady;
    for (int k = LASTQ; k >= 1; k--) begin
      popV[k-1] = status.notEmpty[k-1] & (~status.full[k] | popV[k]);
    end
  end

  assign inReady     = ~status.full[0] | popV[0];
  assign outValid    = status.notEmpty[LASTQ];
  assign strobe.pop  = popV;
  assign strobe.push = {popV[NUM_QUEUES-2:0], inValid & inReady};

endmodule

// File: rtl/elastic_dp.sv
module elastic_dp
  import elastic_pkg::*;
#(
  parameter int                DATA_W      = 16,
  parameter int                DEPTH       = 2,
  parameter logic [DATA_W-1:0] STAGE1_ADD  = '0,
  parameter logic [DATA_W-1:0] STAGE2_MASK = '0,
  localparam int               CW          = $clog2(DEPTH + 1)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  strobe_t                         strobe,
  input  logic [DATA_W-1:0]               inData,
  output logic [DATA_W-1:0]               outData,
  output status_t                         status,
  output logic [NUM_QUEUES-1:0][CW-1:0]   qCount
);

  logic [DATA_W-1:0]     head [NUM_QUEUES];
  logic [NUM_QUEUES-1:0] ne;
  logic [NUM_QUEUES-1:0] fl;

  // stand-in transforms, one per stage
  function automatic logic [DATA_W-1:0] xform(input int idx, input logic [DATA_W-1:0] x);
    case (idx)
      1:       return x + STAGE1_ADD;
      2:       return x ^ STAGE2_MASK;
      default: return {x[DATA_W-2:0], x[DATA_W-1]};
    endcase
  endfunction

  for (genvar q = 0; q < NUM_QUEUES; q++) begin : gQueue
    logic [DATA_W-1:0] din;
    if (q == 0) begin : gEntry
      assign din = inData;
    end else begin : gStage
      assign din = xform(q, head[q-1]);
    end
    elastic_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uQueue (
      .clk      (clk),
      .rst      (rst),
      .push     (strobe.push[q]),
      .pop      (strobe.pop[q]),
      .pushData (din),
      .headData (head[q]),
      .notEmpty (ne[q]),
      .full     (fl[q]),
      .count    (qCount[q])
    );
  end

  assign outData         = head[NUM_QUEUES-1];
  assign status.notEmpty = ne;
  assign status.full     = fl;

endmodule

// File: rtl/elastic_pipe.sv
module elastic_pipe
  import elastic_pkg::*;
#(
  parameter int                DATA_W      = 16,
  parameter int                DEPTH       = 2,
  parameter logic [DATA_W-1:0] STAGE1_ADD  = 16'h0035,
  parameter logic [DATA_W-1:0] STAGE2_MASK = 16'hA5C3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData
);

  localparam int CW = $clog2(DEPTH + 1);

  strobe_t                         strobe;
  status_t                         status;
  logic [NUM_QUEUES-1:0][CW-1:0]   qCount;

  elastic_ctrl uCtrl (
    .status   (status),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  elastic_dp #(
    .DATA_W      (DATA_W),
    .DEPTH       (DEPTH),
    .STAGE1_ADD  (STAGE1_ADD),
    .STAGE2_MASK (STAGE2_MASK)
  ) uDp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .inData  (inData),
    .outData (outData),
    .status  (status),
    .qCount  (qCount)
  );

endmodule

// File: rtl/elastic_pipe_chk.sv
module elastic_pipe_chk
  import elastic_pkg::*;
#(
  parameter int  DATA_W = 16,
  parameter int  DEPTH  = 2,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          inValid,
  input logic                          inReady,
  input logic                          outValid,
  input logic                          outReady,
  input logic [DATA_W-1:0]             outData,
  input strobe_t                       strobe,
  input logic [NUM_QUEUES-1:0][CW-1:0] qCount
);

  int  held;
  logic inAcc;
  logic outAcc;

  always_comb begin
    held = 0;
    for (int k = 0; k < NUM_QUEUES; k++) held += int'(qCount[k]);
  end
  assign inAcc  = inValid & inReady;
  assign outAcc = outValid & outReady;

  // R1
  reset_empty_chk: assert property (@(posedge clk)
    rst |=> (!outValid && inReady && held == 0));

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R8
  conserve_chk: assert property (@(posedge clk) disable iff (rst)
    (inAcc || !inAcc) |=> (held == $past(held) + int'($past(inAcc)) - int'($past(outAcc))));

  for (genvar q = 0; q < NUM_QUEUES; q++) begin : gQChk
    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      (qCount[q] == CW'(DEPTH) && !strobe.pop[q]) |-> !strobe.push[q]);
    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
      (qCount[q] == '0) |-> !strobe.pop[q]);
    // R5
    occupancy_cap_chk: assert property (@(posedge clk) disable iff (rst)
      qCount[q] <= CW'(DEPTH));
  end

endmodule

bind elastic_pipe elastic_pipe_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uChk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData),
  .strobe   (strobe),
  .qCount   (qCount)
);

// File: tb/tb_elastic_pipe.sv
`timescale 1ns/1ps
module tb_elastic_pipe;

  localparam int              W     = 16;
  localparam int              DEPTH = 2;
  localparam logic [W-1:0]    ADD   = 16'h0035;
  localparam logic [W-1:0]    MASK  = 16'hA5C3;
  localparam int              CAP   = 4 * DEPTH;

  logic         clk = 1'b0;
  logic         rst;
  logic         inValid;
  logic         inReady;
  logic [W-1:0] inData;
  logic         outValid;
  logic         outReady;
  logic [W-1:0] outData;

  int checks = 0;
  int fails  = 0;
  int accepted = 0;
  int delivered = 0;
  bit summaryDone = 1'b0;
  logic [W-1:0] expQ[$];

  always #2 clk = ~clk;

  elastic_pipe #(.DATA_W(W), .DEPTH(DEPTH), .STAGE1_ADD(ADD), .STAGE2_MASK(MASK)) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  function automatic logic [W-1:0] model(input logic [W-1:0] x);
    logic [W-1:0] t;
    t = (x + ADD) ^ MASK;
    return {t[W-2:0], t[W-1]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    end
  endtask

  // scoreboard: samples 1 ns after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst) begin
        expQ.delete();
      end else begin
        if (outValid && outReady) begin
          delivered++;
          if (expQ.size() == 0) begin
            check(1'b0, "R8", "word delivered with none outstanding", outData, 0);
          end else begin
            logic [W-1:0] e;
            e = expQ.pop_front();
            check(outData == e, "R2", "delivered word", outData, e);
          end
        end
        if (inValid && inReady) begin
          expQ.push_back(model(inData));
          accepted++;
        end
      end
    end
  end

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    inData = '0;
    idleCycles(3);
    rst = 1'b0;
    #1;
    // R1: state left by the last reset edge
    check(outValid == 1'b0, "R1", "outValid after reset", outValid, 0);
    check(inReady == 1'b1, "R1", "inReady after reset", inReady, 1);
  endtask

  task automatic testLatency();
    logic [W-1:0] x;
    x = 16'h1234;
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b1;
    inData = x;
    #1;
    check(inReady == 1'b1, "R3", "inReady on empty pipe", inReady, 1);
    @(negedge clk);
    inValid = 1'b0;
    for (int s = 1; s <= 4; s++) begin
      if (s > 1) @(negedge clk);
      #1;
      if (s < 4) check(outValid == 1'b0, "R3", $sformatf("early outValid at sample %0d", s), outValid, 0);
      else begin
        check(outValid == 1'b1, "R3", "outValid three edges after accept", outValid, 1);
        check(outData == model(x), "R3", "result at latency", outData, model(x));
      end
    end
    idleCycles(3);
  endtask

  task automatic testThroughput();
    int stalls = 0;
    int first = -1;
    int last = -1;
    int ones = 0;
    outReady = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      inValid = (i < 20);
      inData = W'(16'h0100 + i);
      #1;
      if (i < 20 && !inReady) stalls++;
      if (outValid) begin
        ones++;
        if (first < 0) first = i;
        last = i;
      end
    end
    inValid = 1'b0;
    // R4
    check(stalls == 0, "R4", "inReady drops while streaming", stalls, 0);
    check(ones == 20, "R4", "valid output samples", ones, 20);
    check(first == 4, "R4", "first valid sample", first, 4);
    check(last - first + 1 == ones, "R4", "gap-free output run", last - first + 1, ones);
  endtask

  task automatic testFillAndRelease();
    int acc = 0;
    int changes = 0;
    logic [W-1:0] held;
    logic [W-1:0] firstIn;
    bit seen = 1'b0;
    outReady = 1'b0;
    firstIn = 16'h0003;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inData = W'(i * 7 + 3);
      #1;
      if (inReady) acc++;
      if (outValid) begin
        if (!seen) begin
          held = outData;
          seen = 1'b1;
        end else if (outData != held) changes++;
      end
    end
    // R5: capacity with the consumer stalled
    check(acc == CAP, "R5", "words accepted while stalled", acc, CAP);
    check(inReady == 1'b0, "R5", "inReady when pipeline full", inReady, 0);
    // R7
    check(changes == 0, "R7", "outData changes while stalled", changes, 0);
    check(held == model(firstIn), "R7", "held output word", held, model(firstIn));
    @(negedge clk);
    inData = 16'h00AA;
    outReady = 1'b1;
    #1;
    // R6: same-cycle release through every full queue
    check(inReady == 1'b1, "R6", "inReady in release cycle", inReady, 1);
    @(negedge clk);
    inValid = 1'b0;
    idleCycles(14);
    #1;
    check(outValid == 1'b0, "R5", "pipeline drained", outValid, 0);
  endtask

  task automatic testMidReset();
    outReady = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inData = W'(16'h0C00 + i);
    end
    @(negedge clk);
    inValid = 1'b0;
    #1;
    check(outValid == 1'b1, "R1", "data held before mid-stream reset", outValid, 1);
    doReset();
    outReady = 1'b1;
    idleCycles(6);
    #1;
    // R1: nothing survives the reset
    check(outValid == 1'b0, "R1", "no output after mid-stream reset", outValid, 0);
  endtask

  task automatic testRandom();
    logic [15:0] lfsr;
    int a0;
    int d0;
    lfsr = 16'hACE1;
    a0 = accepted;
    d0 = delivered;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      inValid = lfsr[3] | lfsr[9];
      outReady = lfsr[5] | lfsr[1];
      inData = lfsr ^ W'(i);
    end
    @(negedge clk);
    inValid = 1'b0;
    outReady = 1'b1;
    idleCycles(20);
    // R8
    check(accepted - a0 > 100, "R8", "words carried under stalls", accepted - a0, 101);
    check(accepted - a0 == delivered - d0, "R8", "accepted vs delivered", delivered - d0, accepted - a0);
    check(expQ.size() == 0, "R8", "words left outstanding", expQ.size(), 0);
  endtask

  initial begin
    #(50000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1;
    inValid = 1'b0;
    inData = '0;
    outReady = 1'b0;
    doReset();
    testLatency();
    testThroughput();
    testFillAndRelease();
    testMidReset();
    testRandom();
    summary();
    $finish;
  end

endmodule